// File: doc/BRIEF.md
# Self-correcting decade twisted-ring counter

This block is a five-stage twisted-ring counter. It steps through ten register states and turns each state into one of ten decoded outputs, so exactly one output is high for each count. A carry output gives a square wave with a 50% duty cycle at one tenth of the clock rate. It serves as a decade divider, a ten-phase sequencer or a one-of-ten step generator.

A synchronous hold input stops the count. It acts as an enable term on the register, so the clock is never gated. An asynchronous active-high reset clears the register. The feedback into the third stage is changed so that any of the 22 five-bit patterns outside the count cycle drains back into the cycle, even if nothing outside the block intervenes.

Top module: `jc_decade_counter`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, all stages are zero: `dec_o` equals 10'b00_0000_0001 (bit 0 set) and `carry_o` is 1.
- R2: With `hold_i` low and `rst_i` low, each rising clock edge moves the count from k to (k+1) mod 10. The high bit of `dec_o` walks 0,1,…,9,0 in that order, and only one register stage changes per step.
- R3: With `hold_i` high at a rising edge, the register and all outputs keep their values. Counting resumes from the held count once `hold_i` is low again.
- R4: In every count k (0..9), exactly one bit of `dec_o` is high, and that bit is bit k. Bit 0 is stage1=0 and stage5=0. Bit 5 is stage1=1 and stage5=1. Bit j (1..4) is stage j=1 and stage j+1=0. Bit j (6..9) is stage j−5=0 and stage j−4=1.
- R5: `carry_o` equals the inverse of stage 5. It is 1 for counts 0..4 and 0 for counts 5..9.
- R6: From any of the 22 illegal register patterns, the counter is back in the legal ten-state cycle after at most 10 enabled clock edges, and it stays there.
- R7: Raising `rst_i` clears the register at once, with no clock edge needed, so `dec_o` shows count 0 before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active, never gated |
| rst_i | input | 1 | Asynchronous reset, active high, clears all stages |
| hold_i | input | 1 | Synchronous count inhibit; high freezes the count |
| dec_o | output | 10 | One-hot decoded count, bit k high in count k |
| carry_o | output | 1 | Inverse of stage 5: high for counts 0..4 |

## Verification
The step and hold properties assume that `hold_i` and `rst_i` change only away from the rising edge, and that the register holds a legal pattern whenever it is not recovering. The stimulus changes inputs on falling edges only. Illegal patterns are placed in the register only in the gap straight after a reset cycle, so the one-stage-step property never sees a jump that the counter did not make. The recovery bound is checked by a run counter of enabled illegal cycles. The bench starts the counter from all 22 illegal patterns and then follows ten more counts against its own model.

// File: rtl/jc_pkg.sv
package jc_pkg;

  // Default geometry of the ring
  localparam int JC_STAGES    = 5;
  // Zero-based index of the stage that carries the correcting feedback
  localparam int JC_FIX_STAGE = 2;

  // How a decoder reads its two neighbouring stage bits
  typedef enum logic [1:0] {
    PAIR_LOW_LOW   = 2'd0,
    PAIR_HIGH_HIGH = 2'd1,
    PAIR_ONE_ZERO  = 2'd2,
    PAIR_ZERO_ONE  = 2'd3
  } jc_pair_e;

  // Two-input decode of an adjacent bit pair
  function automatic logic jc_pair(input logic a, input logic b, input jc_pair_e kind);
    logic r;
    case (kind)
      PAIR_LOW_LOW:   r = ~a & ~b;
      PAIR_HIGH_HIGH: r =  a &  b;
      PAIR_ONE_ZERO:  r =  a & ~b;
      default:        r = ~a &  b;
    endcase
    return r;
  endfunction

  // Correcting next value for the fix stage: copy the previous stage, but
  // only while the stage before it or the fix stage itself is set
  function automatic logic jc_fix_bit(input logic prev, input logic prev2, input logic self_q);
    return prev & (prev2 | self_q);
  endfunction

endpackage

// File: rtl/jc_ring_reg.sv
module jc_ring_reg
  import jc_pkg::*;
#(
  parameter int STAGES    = JC_STAGES,
  parameter int FIX_STAGE = JC_FIX_STAGE
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              advance_i,
  output logic [STAGES-1:0] stage_o,
  output logic              legal_o
);

  localparam int STATES = 2 * STAGES;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] next_w;

  // Pattern held in the register during count k of the legal cycle
  function automatic logic [STAGES-1:0] count_pattern(input int k);
    logic [STAGES-1:0] p;
    for (int i = 0; i < STAGES; i++) begin
      p[i] = (k < STAGES) ? (i < k) : (i >= k - STAGES);
    end
    return p;
  endfunction

  function automatic logic in_cycle(input logic [STAGES-1:0] s);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < STATES; k++) begin
      if (s == count_pattern(k)) hit = 1'b1;
    end
    return hit;
  endfunction

  // Next-state network: twisted feedback into stage 0, plain shift elsewhere,
  // correcting gate on the fix stage
  for (genvar i = 0; i < STAGES; i++) begin : g_next
    if (i == 0) begin : g_twist
      assign next_w[i] = ~stage_q[STAGES-1];
    end else if (i == FIX_STAGE) begin : g_fix
      assign next_w[i] = jc_fix_bit(stage_q[i-1], stage_q[i-2], stage_q[i]);
    end else begin : g_shift
      assign next_w[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      stage_q <= '0;
    end else if (advance_i) begin
      stage_q <= next_w;
    end
  end

  assign stage_o = stage_q;
  assign legal_o = in_cycle(stage_q);

  // R1: register reads zero at every edge inside a held reset
  always @(posedge clk_i) begin
    if (rst_i && $past(rst_i)) begin
      p_reset_clear_r1: assert (stage_q == '0)
        else $error("reset did not clear the ring");
    end
  end

  // R2: an enabled step from a legal pattern flips exactly one stage
  p_one_stage_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (legal_o && advance_i && !rst_i) |=> ($countones(stage_q ^ $past(stage_q)) == 1));

  // R2: an enabled step from a legal pattern lands on a legal pattern
  p_stay_legal_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (legal_o && advance_i && !rst_i) |=> legal_o);

  // R3: no enable, no change
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!advance_i && !rst_i) |=> $stable(stage_q));

endmodule

// File: rtl/jc_phase_decode.sv
module jc_phase_decode
  import jc_pkg::*;
#(
  parameter int STAGES = JC_STAGES
) (
  input  logic [STAGES-1:0]   stage_i,
  output logic [2*STAGES-1:0] dec_o,
  output logic                carry_o
);

  localparam int OUTS = 2 * STAGES;

  // Each output looks at one adjacent pair of stages only
  for (genvar k = 0; k < OUTS; k++) begin : g_dec
    if (k == 0) begin : g_all_low
      assign dec_o[k] = jc_pair(stage_i[0], stage_i[STAGES-1], PAIR_LOW_LOW);
    end else if (k == STAGES) begin : g_all_high
      assign dec_o[k] = jc_pair(stage_i[0], stage_i[STAGES-1], PAIR_HIGH_HIGH);
    end else if (k < STAGES) begin : g_fill
      assign dec_o[k] = jc_pair(stage_i[k-1], stage_i[k], PAIR_ONE_ZERO);
    end else begin : g_drain
      assign dec_o[k] = jc_pair(stage_i[k-STAGES-1], stage_i[k-STAGES], PAIR_ZERO_ONE);
    end
  end

  assign carry_o = ~stage_i[STAGES-1];

endmodule

// File: rtl/jc_decade_counter.sv
module jc_decade_counter
  import jc_pkg::*;
#(
  parameter int STAGES    = JC_STAGES,
  parameter int FIX_STAGE = JC_FIX_STAGE
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                hold_i,
  output logic [2*STAGES-1:0] dec_o,
  output logic                carry_o
);

  localparam int OUTS          = 2 * STAGES;
  localparam int RECOVER_LIMIT = 2 * STAGES;
  localparam int RUN_W         = $clog2(RECOVER_LIMIT + 2);

  logic [STAGES-1:0] stage_w;
  logic              legal_w;
  logic              advance_w;

  assign advance_w = ~hold_i;

  jc_ring_reg #(
    .STAGES    (STAGES),
    .FIX_STAGE (FIX_STAGE)
  ) u_ring (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .advance_i (advance_w),
    .stage_o   (stage_w),
    .legal_o   (legal_w)
  );

  jc_phase_decode #(
    .STAGES (STAGES)
  ) u_dec (
    .stage_i (stage_w),
    .dec_o   (dec_o),
    .carry_o (carry_o)
  );

  // Length of the current run of enabled edges spent outside the cycle
  logic [RUN_W-1:0] stray_run_q;
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      stray_run_q <= '0;
    end else if (legal_w) begin
      stray_run_q <= '0;
    end else if (advance_w && (stray_run_q != RUN_W'(RECOVER_LIMIT + 1))) begin
      stray_run_q <= stray_run_q + 1'b1;
    end
  end

  // R4: legal register pattern decodes to exactly one output
  p_onehot_legal_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    legal_w |-> $onehot(dec_o));

  // R5: carry high exactly when no upper-half output is active
  p_carry_half_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    legal_w |-> (carry_o == ~|dec_o[OUTS-1:STAGES]));

  // R6: the ring never spends more than the bound of enabled edges outside the cycle
  p_recover_bound_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    stray_run_q <= RUN_W'(RECOVER_LIMIT));

endmodule

// File: tb/jc_decade_counter_tb.sv
module jc_decade_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 5;
  localparam int NOUT       = 2 * N;

  logic            clk  = 1'b0;
  logic            rst  = 1'b1;
  logic            hold = 1'b0;
  logic [NOUT-1:0] dec;
  logic            carry;

  int n_vec  = 0;
  int n_fail = 0;
  int cnt    = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jc_decade_counter dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .hold_i  (hold),
    .dec_o   (dec),
    .carry_o (carry)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare outputs with the model count
  task automatic compare_model(input string req_dec);
    check(dec == NOUT'(1) << cnt, req_dec, int'(dec), 1 << cnt);
    check($countones(dec) == 1, "R4", $countones(dec), 1);
    check(carry == (cnt < 5), "R5", int'(carry), int'(cnt < 5));
  endtask

  // Advance the model on each rising edge, compare on the falling edge
  task automatic run_cycles(input int n, input string req_dec);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (rst) cnt = 0;
      else if (!hold) cnt = (cnt + 1) % 10;
      @(negedge clk);
      compare_model(req_dec);
    end
  endtask

  initial begin
    bit [31:0] legal_map;
    logic [N-1:0] s;
    logic [N-1:0] bad;
    int n_bad;
    int held;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(dec == NOUT'(1), "R1", int'(dec), 1);
    check(carry == 1'b1, "R1", int'(carry), 1);
    rst = 1'b0;
    cnt = 0;

    // R2 / R4 / R5: free counting over more than two full wraps
    run_cycles(25, "R2");

    // R3: hold for several edges
    hold = 1'b1;
    held = cnt;
    run_cycles(7, "R3");
    check(cnt == held, "R3", cnt, held);
    hold = 1'b0;
    run_cycles(12, "R3");

    // R3: alternating hold pattern
    for (int i = 0; i < 20; i++) begin
      hold = (i % 2 == 1);
      run_cycles(1, "R3");
    end
    hold = 1'b0;
    run_cycles(3, "R2");

    // R7: asynchronous reset acts before any clock edge
    #2 rst = 1'b1;
    #1;
    check(dec == NOUT'(1), "R7", int'(dec), 1);
    check(carry == 1'b1, "R7", int'(carry), 1);
    cnt = 0;
    run_cycles(1, "R7");
    rst = 1'b0;
    run_cycles(4, "R2");

    // R6: enumerate the legal cycle behaviourally, start from every other pattern
    legal_map = '0;
    s = '0;
    for (int i = 0; i < 10; i++) begin
      legal_map[s] = 1'b1;
      s = {s[N-2:0], ~s[N-1]};
    end
    n_bad = 0;
    for (int y = 0; y < 32; y++) begin
      if (!legal_map[y]) begin
        n_bad++;
        bad = N'(y);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 force dut_i.u_ring.stage_q = bad;
        #1 release dut_i.u_ring.stage_q;
        repeat (10) @(negedge clk);
        check($countones(dec) == 1, "R6", int'(dec), 0);
        cnt = 0;
        for (int k = 0; k < NOUT; k++) if (dec[k]) cnt = k;
        run_cycles(11, "R6");
      end
    end
    check(n_bad == 22, "R6", n_bad, 22);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule